// File: doc/BRIEF.md
# Configurable GPIO Bank with Group Interrupt

This block manages a bank of general-purpose pins. Every pin owns an 8-bit setup register. The register picks the pin's role: plain GPIO, or one of three alternate functions. In the same register it also chooses the data direction, a polarity flip, the driver style and whether the pin takes part in the bank's interrupt. In GPIO mode the block drives the pad from a data register and reports the pad level back. In alternate mode it passes the pad between the pad and an internal function source. The internal source then decides the direction, and the polarity flip has no effect.

Every pin that is acting as an input and has its interrupt enabled is ORed into one active-high group interrupt. A digital filter can be switched into that path so that switches and push-buttons can be wired straight to the pins. When the filter is on, the interrupt only changes after the combined request has held a new level for a programmed number of prescaled ticks. With the default values this is 1 ms at 50 MHz.

Software reaches the block through a simple register port. Addresses 0 to NUM_PINS-1 are the pin setup registers. Address NUM_PINS is the filter control register, with the enable in bit 0. Address NUM_PINS+1 is the pin data register. A write takes effect on the clock edge. A read returns data combinationally. The parameters must satisfy NUM_PINS between 2 and 8, TICK_DIV of at least 2 and DEB_TICKS of at least 2.

Top module: `gpio_bank_irq`

## Requirements
- R1: Setup bit 0 sets the direction in GPIO mode. A value of 1 makes the pin an input, so pad_oe is 0. A value of 0 makes it an output, so pad_oe is 1 when the driver is push-pull.
- R2: Setup bit 1 flips the pin in GPIO mode only. An output drives the written data XOR the bit. An input reads back the pad level XOR the bit.
- R3: Setup bits [4:3] choose the function. Code 00 is GPIO. Code k (1 to 3) takes the pad value from alt_out_i[(k-1)*NUM_PINS+p] and the drive enable from alt_dir_i[(k-1)*NUM_PINS+p] (1 means drive). In that case setup bit 0 and setup bit 1 are ignored.
- R4: Tap alt_in_o[(k-1)*NUM_PINS+p] carries the synchronized pad level, never inverted, while pin p selects code k. At all other times the tap holds 1.
- R5: Setup bit 7 selects open-drain. A drive of 0 gives pad_out=0 and pad_oe=1. A drive of 1 gives pad_oe=0. Bit 7 = 0 drives both levels.
- R6: Setup bit 5 enables the pin's interrupt. The group request is the OR, over all pins that are enabled and not driving, of the pin's input level. In GPIO mode the input level includes the polarity flip.
- R7: With the filter off, group_irq follows the group request. A pad change shows on group_irq after the third rising edge: two for synchronization and one for the output register.
- R8: With the filter on (address NUM_PINS, bit 0), group_irq changes only after the request has held a new level for DEB_TICKS ticks of TICK_DIV clocks each. Shorter pulses are dropped.
- R9: A read of address NUM_PINS+1 returns, per pin, the last written bit if the pin is a GPIO output. Otherwise it returns the synchronized input level.
- R10: Reset sets every setup register to 0x01, clears the data register and the filter enable, and sets group_irq to 0. Setup bits 2 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pad_in | input | NUM_PINS | Pad levels seen at the pins |
| pad_out | output | NUM_PINS | Pad drive values |
| pad_oe | output | NUM_PINS | Pad drive enables |
| alt_out_i | input | 3*NUM_PINS | Alternate-function drive values, grouped by function code |
| alt_dir_i | input | 3*NUM_PINS | Alternate-function drive enables, grouped by function code |
| alt_in_o | output | 3*NUM_PINS | Alternate-function input taps, grouped by function code |
| group_irq | output | 1 | Active-high group interrupt |

## Verification
Two things can land in the same cycle. One is a register write that changes a pin's setup. The other is a pad edge on that pin that is already travelling through the synchronizer toward the interrupt. The bench provokes this by switching a pin's polarity, function or interrupt enable while its pad is held high. It then checks that group_irq settles to the value the new setup predicts, after the register and synchronizer delay. A second case sets the filter enable while the request is high. This is judged by requiring that a pulse shorter than the filter window never reaches group_irq, and that a level held past the window does.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int FUNC_W  = 2;
    localparam int NUM_ALT = (2 ** FUNC_W) - 1;

    // Field order is the register layout: bit 7 down to bit 0.
    typedef struct packed {
        logic              open_drain; // bit 7
        logic              rsv6;       // bit 6
        logic              irq_en;     // bit 5
        logic [FUNC_W-1:0] func;       // bits 4:3
        logic              rsv2;       // bit 2
        logic              invert;     // bit 1
        logic              dir_in;     // bit 0
    } pin_cfg_t;

    localparam logic [7:0] CFG_RESET = 8'h01;
    localparam logic [7:0] CFG_MASK  = 8'hBB;

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_pkg::*;
(
    input  pin_cfg_t           cfg,
    input  logic               dout,
    input  logic               pad_lvl,
    input  logic [NUM_ALT-1:0] alt_out,
    input  logic [NUM_ALT-1:0] alt_dir,
    output logic               pad_out,
    output logic               pad_oe,
    output logic               rd_bit,
    output logic               irq_req,
    output logic [NUM_ALT-1:0] alt_tap
);

    logic is_gpio;
    logic drive_en;
    logic drive_val;
    logic in_level;
    logic alt_o_sel;
    logic alt_d_sel;
    logic unused_rsv;

    assign unused_rsv = cfg.rsv2 ^ cfg.rsv6;
    assign is_gpio    = (cfg.func == '0);

    always_comb begin
        alt_o_sel = 1'b0;
        alt_d_sel = 1'b0;
        for (int k = 0; k < NUM_ALT; k++) begin
            if (cfg.func == FUNC_W'(k + 1)) begin
                alt_o_sel = alt_out[k];
                alt_d_sel = alt_dir[k];
            end
        end
    end

    always_comb begin
        drive_en  = is_gpio ? ~cfg.dir_in : alt_d_sel;
        drive_val = is_gpio ? (dout ^ cfg.invert) : alt_o_sel;
        pad_out   = drive_val & ~cfg.open_drain;
        pad_oe    = drive_en & (~cfg.open_drain | ~drive_val);
        in_level  = is_gpio ? (pad_lvl ^ cfg.invert) : pad_lvl;
        irq_req   = cfg.irq_en & ~drive_en & in_level;
        rd_bit    = (is_gpio & ~cfg.dir_in) ? dout : in_level;
    end

    generate
        for (genvar k = 0; k < NUM_ALT; k++) begin : g_tap
            assign alt_tap[k] = (cfg.func == FUNC_W'(k + 1)) ? pad_lvl : 1'b1;
        end
    endgenerate

endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
    parameter int TICK_DIV  = 50,
    parameter int DEB_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);

    localparam int TCW = $clog2(TICK_DIV);
    localparam int DCW = $clog2(DEB_TICKS);
    localparam logic [TCW-1:0] TICK_LAST = TCW'(TICK_DIV - 1);
    localparam logic [DCW-1:0] DEB_LAST  = DCW'(DEB_TICKS - 1);

    typedef struct packed {
        logic [TCW-1:0] tick_cnt;
        logic [DCW-1:0] deb_cnt;
        logic           filt;
    } deb_st_t;

    deb_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.tick_cnt == TICK_LAST);
        st_d.tick_cnt = tick ? '0 : st_q.tick_cnt + 1'b1;
        if (raw_i == st_q.filt) begin
            st_d.deb_cnt = '0;
        end else if (tick) begin
            if (st_q.deb_cnt == DEB_LAST) begin
                st_d.filt    = raw_i;
                st_d.deb_cnt = '0;
            end else begin
                st_d.deb_cnt = st_q.deb_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o = st_q.filt;

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gpio_pkg::*;
#(
    parameter int NUM_PINS  = 8,
    parameter int TICK_DIV  = 50,
    parameter int DEB_TICKS = 1000,
    parameter int AW        = $clog2(NUM_PINS + 2)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [AW-1:0]               reg_addr,
    input  logic [7:0]                  reg_wdata,
    output logic [7:0]                  reg_rdata,
    input  logic [NUM_PINS-1:0]         pad_in,
    output logic [NUM_PINS-1:0]         pad_out,
    output logic [NUM_PINS-1:0]         pad_oe,
    input  logic [NUM_ALT*NUM_PINS-1:0] alt_out_i,
    input  logic [NUM_ALT*NUM_PINS-1:0] alt_dir_i,
    output logic [NUM_ALT*NUM_PINS-1:0] alt_in_o,
    output logic                        group_irq
);

    localparam logic [AW-1:0] ADDR_DEB  = AW'(NUM_PINS);
    localparam logic [AW-1:0] ADDR_DATA = AW'(NUM_PINS + 1);

    typedef struct packed {
        pin_cfg_t [NUM_PINS-1:0] cfg;
        logic [NUM_PINS-1:0]     dout;
        logic                    deb_en;
        logic [NUM_PINS-1:0]     sync1;
        logic [NUM_PINS-1:0]     sync2;
        logic                    irq;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [NUM_PINS-1:0] rd_bits;
    logic [NUM_PINS-1:0] irq_reqs;
    logic                raw_irq;
    logic                filt_irq;

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic [NUM_ALT-1:0] ao, ad, tap;
            for (genvar k = 0; k < NUM_ALT; k++) begin : g_alt
                assign ao[k] = alt_out_i[k*NUM_PINS + p];
                assign ad[k] = alt_dir_i[k*NUM_PINS + p];
                assign alt_in_o[k*NUM_PINS + p] = tap[k];
            end
            gpio_pin_cell u_cell (
                .cfg     (st_q.cfg[p]),
                .dout    (st_q.dout[p]),
                .pad_lvl (st_q.sync2[p]),
                .alt_out (ao),
                .alt_dir (ad),
                .pad_out (pad_out[p]),
                .pad_oe  (pad_oe[p]),
                .rd_bit  (rd_bits[p]),
                .irq_req (irq_reqs[p]),
                .alt_tap (tap)
            );
        end
    endgenerate

    assign raw_irq = |irq_reqs;

    gpio_debounce #(
        .TICK_DIV  (TICK_DIV),
        .DEB_TICKS (DEB_TICKS)
    ) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_irq),
        .filt_o (filt_irq)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = pad_in;
        st_d.sync2 = st_q.sync1;
        st_d.irq   = st_q.deb_en ? filt_irq : raw_irq;
        if (reg_wr) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (reg_addr == AW'(p)) st_d.cfg[p] = pin_cfg_t'(reg_wdata & CFG_MASK);
            end
            if (reg_addr == ADDR_DEB)  st_d.deb_en = reg_wdata[0];
            if (reg_addr == ADDR_DATA) st_d.dout   = reg_wdata[NUM_PINS-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (reg_addr == AW'(p)) reg_rdata = st_q.cfg[p];
        end
        if (reg_addr == ADDR_DEB)  reg_rdata = {7'b0, st_q.deb_en};
        if (reg_addr == ADDR_DATA) reg_rdata = 8'(rd_bits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int p = 0; p < NUM_PINS; p++) st_q.cfg[p] <= pin_cfg_t'(CFG_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign group_irq = st_q.irq;

endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_PINS-1:0][7:0]      cfg,
    input logic [NUM_PINS-1:0]           pad_out,
    input logic [NUM_PINS-1:0]           pad_oe,
    input logic                          raw_irq,
    input logic                          filt_irq,
    input logic                          deb_en,
    input logic                          group_irq
);

    logic any_en;
    always_comb begin
        any_en = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) any_en = any_en | cfg[p][5];
    end

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            AST_GPIO_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg[p][4:3] == 2'b00 && cfg[p][0]) |-> !pad_oe[p]); // R1
            AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg[p][7] && pad_oe[p]) |-> !pad_out[p]); // R5
        end
    endgenerate

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |-> !raw_irq); // R6

    AST_IRQ_DIRECT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !deb_en |=> (group_irq == $past(raw_irq))); // R7

    AST_FILT_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_irq != $past(filt_irq)) |-> (filt_irq == $past(raw_irq))); // R8

endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (st_q.cfg),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .raw_irq   (raw_irq),
    .filt_irq  (filt_irq),
    .deb_en    (st_q.deb_en),
    .group_irq (group_irq)
);

// File: tb/gpio_bank_irq_tb.sv
module gpio_bank_irq_tb;

    localparam int N  = 4;
    localparam int AW = 3;
    localparam int NV = 11;

    // [15:8] setup, [7] data, [6] pad, [5] alt value, [4] alt drive,
    // [2] expected pad_out, [1] expected pad_oe, [0] expected read bit (pin 0)
    localparam logic [15:0] VEC [NV] = '{
        16'h0141, 16'h0344, 16'h0087, 16'h0283, 16'h8002, 16'h8081,
        16'h0865, 16'h0912, 16'h0A77, 16'h9871, 16'h9812
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic [3*N-1:0] alt_out_i = '0, alt_dir_i = '0, alt_in_o;
    logic          group_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic seen;

    always #10 clk = ~clk;

    gpio_bank_irq #(.NUM_PINS(N), .TICK_DIV(4), .DEB_TICKS(6), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_out_i(alt_out_i),
        .alt_dir_i(alt_dir_i), .alt_in_o(alt_in_o), .group_irq(group_irq)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    initial begin
        #4_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        cyc(2); rst_n = 1'b1; cyc(3);

        // R10 reset state
        for (int p = 0; p < N; p++) begin
            rd(p, d); check(d == 8'h01, "R10 reset setup", d, 8'h01);
        end
        rd(N, d);     check(d == 8'h00, "R10 reset filter enable", d, 0);
        rd(N + 1, d); check(d == 8'h00, "R10 reset data", d, 0);
        check(group_irq == 1'b0, "R10 reset irq", group_irq, 0);
        wr(1, 8'hFF); rd(1, d); check(d == 8'hBB, "R10 reserved bits", d, 8'hBB);
        wr(1, 8'h01);

        // R1 R2 R3 R5 R9 vector walk on pin 0
        for (int v = 0; v < NV; v++) begin
            wr(0, VEC[v][15:8]);
            wr(N + 1, {7'b0, VEC[v][7]});
            pad_in[0] = VEC[v][6];
            alt_out_i = {3*N{VEC[v][5]}};
            alt_dir_i = {3*N{VEC[v][4]}};
            cyc(4);
            rd(N + 1, d);
            check({pad_out[0], pad_oe[0], d[0]} == VEC[v][2:0],
                  "R1/R2/R3/R5/R9 vector", {pad_out[0], pad_oe[0], d[0]}, VEC[v][2:0]);
        end
        wr(0, 8'h01); pad_in = '0; alt_out_i = '0; alt_dir_i = '0;

        // R4 alternate taps on pin 2
        wr(2, 8'h13); pad_in[2] = 1'b0; cyc(4);
        check(alt_in_o[1*N+2] == 1'b0, "R4 selected tap not inverted", alt_in_o[1*N+2], 0);
        check(alt_in_o[0*N+2] == 1'b1 && alt_in_o[2*N+2] == 1'b1, "R4 idle taps",
              {alt_in_o[0*N+2], alt_in_o[2*N+2]}, 3);
        pad_in[2] = 1'b1; cyc(4);
        check(alt_in_o[1*N+2] == 1'b1, "R4 selected tap high", alt_in_o[1*N+2], 1);
        wr(2, 8'h01); pad_in[2] = 1'b0;

        // R6 group request
        wr(1, 8'h21); pad_in[3] = 1'b1; pad_in[1] = 1'b0; cyc(4);
        check(group_irq == 1'b0, "R6 disabled pin ignored", group_irq, 0);
        pad_in[1] = 1'b1; cyc(4);
        check(group_irq == 1'b1, "R6 enabled input raises", group_irq, 1);
        wr(1, 8'h23); cyc(3);
        check(group_irq == 1'b0, "R6 polarity on request", group_irq, 0);
        wr(1, 8'h20); cyc(3);
        check(group_irq == 1'b0, "R6 output pin ignored", group_irq, 0);

        // R7 latency
        wr(1, 8'h21); pad_in[1] = 1'b0; cyc(4);
        pad_in[1] = 1'b1; cyc(2);
        check(group_irq == 1'b0, "R7 not before third edge", group_irq, 0);
        cyc(1);
        check(group_irq == 1'b1, "R7 at third edge", group_irq, 1);

        // R8 filter
        wr(N, 8'h01); cyc(40);
        check(group_irq == 1'b1, "R8 settled high", group_irq, 1);
        pad_in[1] = 1'b0; cyc(40);
        check(group_irq == 1'b0, "R8 settled low", group_irq, 0);
        pad_in[1] = 1'b1; cyc(8); pad_in[1] = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 60; i++) begin cyc(1); seen = seen | group_irq; end
        check(seen == 1'b0, "R8 short pulse dropped", seen, 0);
        pad_in[1] = 1'b1; cyc(10);
        check(group_irq == 1'b0, "R8 not before window", group_irq, 0);
        cyc(40);
        check(group_irq == 1'b1, "R8 long level passes", group_irq, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule